// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block decides, at each instruction boundary, whether the core takes an interrupt, and for a maskable interrupt it runs the acknowledge exchange with the bus controller. A level-sensitive maskable request is honoured only when the interrupt-enable flag is set and the request is still high in the boundary cycle. A non-maskable request is caught on its rising edge, held pending until the next boundary, and wins over a maskable request at that boundary.

For a maskable interrupt the sequencer asks the bus controller for two acknowledge cycles, one after the other, through a request/done handshake. The lock attribute stays high across both cycles without a gap. The 8-bit vector is taken from the data bus when the second cycle completes. For a non-maskable interrupt no bus cycle is run, and a fixed vector is handed over instead. The vector is offered to the core with a valid flag until the core accepts it. No other interrupt is considered before that acceptance.

States: `ST_IDLE` (waiting for a boundary), `ST_ACK1` (first acknowledge cycle), `ST_ACK2` (second acknowledge cycle), `ST_HANDOFF` (vector offered to the core). Transitions:
- `ST_IDLE`→`ST_HANDOFF` on a boundary with a non-maskable interrupt pending.
- `ST_IDLE`→`ST_ACK1` on a boundary with the maskable request high, the flag set and no non-maskable interrupt pending.
- `ST_ACK1`→`ST_ACK2` on bus done.
- `ST_ACK2`→`ST_HANDOFF` on bus done.
- `ST_HANDOFF`→`ST_IDLE` on core accept.

Top module: `intack_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ack_req`, `ack_lock` and `vec_valid` are low.
- R2: A boundary with `irq_level` high but `ie_flag` low starts no acknowledge cycle: `ack_req` stays low.
- R3: Without a boundary strobe no interrupt is serviced, whatever the levels on `irq_level` and `ie_flag`.
- R4: A maskable interrupt is taken only if `irq_level` is high in the boundary cycle itself. If it is low in that cycle, nothing happens.
- R5: An accepted maskable interrupt raises `ack_req` in the cycle after the boundary. It runs exactly two acknowledge cycles: `ack_second` is 0 during the first and 1 during the second. `ack_lock` is high for the whole of both cycles, with no gap between them, including any stall.
- R6: `vec_out` takes the value of `bus_data` at the edge where `ack_done` completes the second cycle. Data present when the first cycle completes is ignored.
- R7: `vec_valid` and `vec_out` remain high and stable until `vec_accept` is sampled high. The cycle after that, `vec_valid` is low.
- R8: A rising edge on `nmi_level` is latched. It is serviced at a later boundary regardless of `ie_flag`, with no bus cycle, `vec_is_nmi`=1 and `vec_out`=NMI_VEC (default 2). A level held high does not fire a second time.
- R9: When a non-maskable interrupt is pending and the maskable request is also valid at the same boundary, the non-maskable one is serviced first. The maskable one is taken at a later boundary.
- R10: While a vector waits for acceptance, boundary strobes are ignored: no `ack_req` is raised and the offered vector does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_level | input | 1 | Level-sensitive maskable interrupt request |
| nmi_level | input | 1 | Non-maskable request, acted on at its rising edge |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| insn_done | input | 1 | One-cycle strobe marking an instruction boundary |
| ack_req | output | 1 | Request to the bus controller for an acknowledge cycle |
| ack_lock | output | 1 | Lock attribute for the current acknowledge cycle |
| ack_second | output | 1 | 0 during the first acknowledge cycle, 1 during the second |
| ack_done | input | 1 | Bus controller finished the current acknowledge cycle |
| bus_data | input | VEC_W | Data bus value, read when the second cycle is done |
| vec_valid | output | 1 | Vector offered to the core |
| vec_is_nmi | output | 1 | The offered vector belongs to a non-maskable interrupt |
| vec_out | output | VEC_W | Interrupt vector |
| vec_accept | input | 1 | The core takes the offered vector |

## Verification
Every input is sampled at a rising edge, and each result appears one edge later:
- `ack_req` rises in the cycle after the boundary strobe.
- `ack_second` switches in the cycle after the first `ack_done`.
- `vec_valid` and the captured `vec_out` appear in the cycle after the second `ack_done`.
- `vec_valid` drops in the cycle after `vec_accept`.

A non-maskable edge needs one edge to be latched and is then serviced at the next boundary. The bench therefore drives on falling edges and checks at the following falling edge, exactly one edge after the stimulus it refers to. Random maskable interrupts with random flag, level, data and stalls are compared against a bench function that predicts whether the acknowledge sequence must start.

// File: rtl/intack_pkg.sv
package intack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK1    = 2'd1,
        ST_ACK2    = 2'd2,
        ST_HANDOFF = 2'd3
    } seq_state_t;

endpackage

// File: rtl/nmi_latch.sv
module nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic consume,
    output logic pending
);

    logic nmi_prev;
    logic edge_seen;

    assign edge_seen = nmi_in & ~nmi_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            pending  <= 1'b0;
        end else begin
            nmi_prev <= nmi_in;
            // a fresh edge wins over the clear from servicing
            pending  <= (pending & ~consume) | edge_seen;
        end
    end

endmodule

// File: rtl/vec_hold.sv
module vec_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         nmi_in,
    output logic [W-1:0] dout,
    output logic         nmi_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            nmi_out <= 1'b0;
        end else if (load) begin
            dout    <= din;
            nmi_out <= nmi_in;
        end
    end

endmodule

// File: rtl/intack_seq.sv
module intack_seq #(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_level,
    input  logic             nmi_level,
    input  logic             ie_flag,
    input  logic             insn_done,
    output logic             ack_req,
    output logic             ack_lock,
    output logic             ack_second,
    input  logic             ack_done,
    input  logic [VEC_W-1:0] bus_data,
    output logic             vec_valid,
    output logic             vec_is_nmi,
    output logic [VEC_W-1:0] vec_out,
    input  logic             vec_accept
);
    import intack_pkg::*;

    localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

    seq_state_t state_q, state_d;
    logic       nmi_pend;
    logic       take_nmi;
    logic       take_irq;
    logic       vec_load;
    logic       vec_src_nmi;
    logic [VEC_W-1:0] vec_din;

    assign take_nmi = (state_q == ST_IDLE) && insn_done && nmi_pend;
    assign take_irq = (state_q == ST_IDLE) && insn_done && !nmi_pend
                      && irq_level && ie_flag;

    nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_in  (nmi_level),
        .consume (take_nmi),
        .pending (nmi_pend)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_nmi)      state_d = ST_HANDOFF;
                else if (take_irq) state_d = ST_ACK1;
            end
            ST_ACK1:    if (ack_done)   state_d = ST_ACK2;
            ST_ACK2:    if (ack_done)   state_d = ST_HANDOFF;
            ST_HANDOFF: if (vec_accept) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ack_req     = 1'b0;
        ack_lock    = 1'b0;
        ack_second  = 1'b0;
        vec_valid   = 1'b0;
        vec_load    = 1'b0;
        vec_src_nmi = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                vec_load    = take_nmi;
                vec_src_nmi = 1'b1;
            end
            ST_ACK1: begin
                ack_req  = 1'b1;
                ack_lock = 1'b1;
            end
            ST_ACK2: begin
                ack_req    = 1'b1;
                ack_lock   = 1'b1;
                ack_second = 1'b1;
                vec_load   = ack_done;
            end
            ST_HANDOFF: vec_valid = 1'b1;
            default: ;
        endcase
    end

    assign vec_din = vec_src_nmi ? NMI_CODE : bus_data;

    vec_hold #(.W(VEC_W)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (vec_load),
        .din     (vec_din),
        .nmi_in  (vec_src_nmi),
        .dout    (vec_out),
        .nmi_out (vec_is_nmi)
    );

endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ie_flag,
    input logic             insn_done,
    input logic             ack_req,
    input logic             ack_lock,
    input logic             ack_second,
    input logic             ack_done,
    input logic             vec_valid,
    input logic             vec_is_nmi,
    input logic [VEC_W-1:0] vec_out,
    input logic             vec_accept
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!ack_req && !ack_lock && !vec_valid));

    a_r2_masked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_req && !vec_valid && insn_done && !ie_flag) |=> !ack_req);

    a_r5_lock_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> ack_lock);

    a_r5_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> !ack_second);

    a_r5_second_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_second && ack_done) |=> (ack_req && ack_second));

    a_r6_end_hands_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_second && ack_done) |=> (vec_valid && !vec_is_nmi));

    a_r7_hold_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_accept) |=> (vec_valid && $stable(vec_out)));

    a_r10_no_ack_while_offered: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !ack_req);

endmodule

bind intack_seq intack_seq_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ie_flag    (ie_flag),
    .insn_done  (insn_done),
    .ack_req    (ack_req),
    .ack_lock   (ack_lock),
    .ack_second (ack_second),
    .ack_done   (ack_done),
    .vec_valid  (vec_valid),
    .vec_is_nmi (vec_is_nmi),
    .vec_out    (vec_out),
    .vec_accept (vec_accept)
);

// File: tb/sim_intack_seq.sv
module sim_intack_seq;

    localparam int CLK_PERIOD = 10;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_level = 1'b0, nmi_level = 1'b0, ie_flag = 1'b0, insn_done = 1'b0;
    logic          ack_done = 1'b0, vec_accept = 1'b0;
    logic [VW-1:0] bus_data = '0;
    logic          ack_req, ack_lock, ack_second, vec_valid, vec_is_nmi;
    logic [VW-1:0] vec_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intack_seq #(.VEC_W(VW), .NMI_VEC(2)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .nmi_level(nmi_level),
        .ie_flag(ie_flag), .insn_done(insn_done), .ack_req(ack_req),
        .ack_lock(ack_lock), .ack_second(ack_second), .ack_done(ack_done),
        .bus_data(bus_data), .vec_valid(vec_valid), .vec_is_nmi(vec_is_nmi),
        .vec_out(vec_out), .vec_accept(vec_accept)
    );

    function automatic bit expect_take(bit lvl, bit flag);
        return lvl && flag;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic boundary(bit lvl, bit flag);
        irq_level = lvl; ie_flag = flag; insn_done = 1'b1;
        step();
        insn_done = 1'b0;
    endtask

    // called one edge after an accepted boundary
    task automatic run_ack(logic [VW-1:0] d1, logic [VW-1:0] d2, int stall);
        check("R5 req raised", ack_req, 1);
        check("R5 first cycle", ack_second, 0);
        for (int i = 0; i < stall; i++) begin
            step();
            check("R5 lock in stall", ack_lock, 1);
        end
        ack_done = 1'b1; bus_data = d1;
        step();
        check("R5 second cycle", ack_second, 1);
        check("R5 lock second", ack_lock, 1);
        ack_done = 1'b1; bus_data = d2;
        step();
        ack_done = 1'b0; bus_data = '0;
        check("R6 vector", vec_out, d2);
        check("R6 valid", vec_valid, 1);
        check("R5 only two cycles", ack_req, 0);
        check("R6 not nmi", vec_is_nmi, 0);
    endtask

    task automatic accept();
        vec_accept = 1'b1;
        step();
        vec_accept = 1'b0;
        check("R7 valid drops", vec_valid, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        step();
        check("R1 req in reset", ack_req, 0);
        check("R1 valid in reset", vec_valid, 0);
        rst_n = 1'b1;
        step();
        check("R1 lock after reset", ack_lock, 0);

        // R3: levels without a boundary
        irq_level = 1'b1; ie_flag = 1'b1;
        repeat (4) step();
        check("R3 no boundary", ack_req, 0);

        // R2: masked
        boundary(1, 0);
        check("R2 masked", ack_req, 0);
        // R4: level low at boundary
        boundary(0, 1);
        check("R4 level low", ack_req, 0);

        // basic maskable
        boundary(1, 1);
        run_ack(8'h11, 8'h5A, 1);
        // R7 hold
        repeat (3) step();
        check("R7 held", vec_valid, 1);
        check("R7 stable", vec_out, 8'h5A);
        // R10: boundary during handoff
        boundary(1, 1);
        check("R10 no ack", ack_req, 0);
        check("R10 vector kept", vec_out, 8'h5A);
        accept();

        // R8: nmi, flag clear
        irq_level = 1'b0;
        nmi_level = 1'b1;
        step();
        boundary(0, 0);
        check("R8 nmi valid", vec_valid, 1);
        check("R8 nmi flag", vec_is_nmi, 1);
        check("R8 nmi vector", vec_out, 2);
        check("R8 no bus", ack_req, 0);
        accept();
        boundary(0, 0);
        check("R8 held level no refire", vec_valid, 0);
        nmi_level = 1'b0;
        step();

        // R9: priority
        nmi_level = 1'b1;
        step();
        boundary(1, 1);
        check("R9 nmi first", vec_is_nmi, 1);
        check("R9 no bus", ack_req, 0);
        accept();
        boundary(1, 1);
        run_ack(8'hAA, 8'hC3, 0);
        accept();
        nmi_level = 1'b0;

        // random maskable traffic
        for (int it = 0; it < 60; it++) begin
            bit lvl, flag;
            logic [VW-1:0] d1, d2;
            lvl = 1'($urandom);
            flag = 1'($urandom);
            d1 = VW'($urandom);
            d2 = VW'($urandom);
            boundary(lvl, flag);
            if (expect_take(lvl, flag)) begin
                run_ack(d1, d2, int'($urandom % 3));
                accept();
            end else begin
                check("R2/R4 random not taken", ack_req, 0);
            end
            repeat (int'($urandom % 2)) step();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule